// File: doc/BRIEF.md
# Single-Pointer Fast Trace-Back Survivor Unit

This block manages the survivor path of a Viterbi decoder. Each accepted stage delivers the add-compare-select decision vector (one bit per trellis state) and the index of the state that currently has the best path metric. The decisions are stored column by column in a ring of k+1 banks, each L/(k-1) columns deep. A single read pointer makes k trellis steps for every accepted stage. During each bank period it first walks back over L columns so that the path has converged. It then decodes the next bank's worth of columns.

The bits from the decode walk appear newest first. They are placed by column position into one half of a double buffer. The other half drains one bit per accepted stage in stage order. The first decoded bit appears after (k+1)·L/(k-1) stages, which is 16 stages for the defaults k=3, L=8, constraint length 3. After that, every accepted stage yields exactly one decoded bit. Path-metric computation and the search for the best state take place upstream of this block.

Top module: `tbu_onepointer`

## Requirements
- R1: While rst_n is low, out_valid is low. After rst_n is released, out_valid stays low until LAT = (k+1)·L/(k-1) stages have been accepted (16 by default).
- R2: For every accepted stage with zero-based index n ≥ LAT, out_valid is high in the clock cycle after the stage is accepted, for that one cycle only.
- R3: The bit output for accepted stage n is the decoded bit of stage n−LAT. Bits therefore come out in stage order. The decoded bit of a stage is the most significant bit of the survivor state at that stage. The encoder shifts its state right by one and places the new input bit in the most significant bit.
- R4: A cycle with in_valid low produces no output in the following cycle, and its in_dec and in_best values have no effect on any later output.
- R5: Each trace-back starts from the in_best value given with the final column of the bank that was most recently completed. The decision bits of states that are off that path have no effect on the output.
- R6: The predecessor of state s is ((s << 1) | in_dec[s]) modulo the number of states, where in_dec bit i belongs to state i.
- R7: A reset in the middle of a stream discards all stored history and restarts the R1 latency count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept one trellis stage this cycle |
| in_dec | input | 2**(K_LEN-1) | Decision bit for each state, bit i for state i |
| in_best | input | K_LEN-1 | Index of the state with the best metric at this stage |
| out_valid | output | 1 | Decoded bit present (registered) |
| out_bit | output | 1 | Decoded bit, in stage order |

## Verification
An error in the bank or column counters shifts the latency or splices the wrong columns together. This appears within one or two bank periods as a missing, extra or misplaced out_valid pulse, or as a run of wrong bits. A wrong start state or a wrong predecessor computation takes the walk off the true path, because the decisions of off-path states are random. The bits of the next drained bank then disagree with the delayed encoder input. A fault in the double buffer reverses or mixes bits within a group of L/(k-1) outputs. This shows one bank period after the faulty fill. The behavioural model in the bench is compared with the outputs on every clock, so the first wrong cycle is reported.

// File: rtl/tbu_pkg.sv
package tbu_pkg;

    // kind of one read step of the single pointer
    typedef enum logic [0:0] {
        PH_TRACE  = 1'b0,
        PH_DECODE = 1'b1
    } step_kind_e;

    // column that lies 'back' positions before 'head' on a ring of 'ring' columns
    function automatic int unsigned wrap_back(input int unsigned head,
                                              input int unsigned back,
                                              input int unsigned ring);
        return (head + ring - (back % ring)) % ring;
    endfunction

endpackage

// File: rtl/tbu_surv_mem.sv
module tbu_surv_mem #(
    parameter int NS   = 4,
    parameter int NCOL = 16,
    parameter int NRD  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NCOL)-1:0]   wr_col,
    input  logic [NS-1:0]             wr_dec,
    input  logic [NRD-1:0][$clog2(NCOL)-1:0] rd_col,
    output logic [NRD-1:0][NS-1:0]    rd_dec
);
    logic [NCOL-1:0][NS-1:0] mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        if (wr_en) mem_d[wr_col] = wr_dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    // one combinational read port per fast step
    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rd_dec[g] = mem_q[rd_col[g]];
    end
endmodule

// File: rtl/tbu_trace_chain.sv
module tbu_trace_chain
    import tbu_pkg::*;
#(
    parameter int SW    = 2,
    parameter int DEPTH = 4,
    parameter int SPEED = 3,
    localparam int NS   = 1 << SW,
    localparam int NCOL = (SPEED + 1) * DEPTH,
    localparam int CW   = $clog2(NCOL),
    localparam int OW   = $clog2(DEPTH),
    localparam int SIW  = $clog2(SPEED * DEPTH + 1),
    localparam int TB_STEPS = (SPEED - 1) * DEPTH
) (
    input  logic [SW-1:0]                start_state,
    input  logic [CW-1:0]                head_col,
    input  logic [SIW-1:0]               step0,
    input  logic [SPEED-1:0][NS-1:0]     rd_dec,
    output logic [SPEED-1:0][CW-1:0]     rd_col,
    output logic [SW-1:0]                end_state,
    output logic [SPEED-1:0]             push_en,
    output logic [SPEED-1:0]             push_bit,
    output logic [SPEED-1:0][OW-1:0]     push_ofs
);
    logic [SPEED:0][SW-1:0] st;

    assign st[0]     = start_state;
    assign end_state = st[SPEED];

    for (genvar g = 0; g < SPEED; g++) begin : g_step
        int unsigned idx;
        logic [CW-1:0] col;
        step_kind_e    kind;
        logic [SW:0]   ext;

        always_comb begin
            idx  = 32'(step0) + 32'(g);
            col  = CW'(wrap_back(32'(head_col), idx + 1, NCOL));
            kind = (idx >= TB_STEPS) ? PH_DECODE : PH_TRACE;
        end

        assign rd_col[g]   = col;
        // predecessor: shift left, decision bit enters at the bottom
        assign ext         = {st[g], rd_dec[g][st[g]]};
        assign st[g+1]     = ext[SW-1:0];
        assign push_en[g]  = (kind == PH_DECODE);
        assign push_bit[g] = st[g][SW-1];
        assign push_ofs[g] = OW'(32'(col) % DEPTH);
    end
endmodule

// File: rtl/tbu_rev_lifo.sv
module tbu_rev_lifo #(
    parameter int DEPTH = 4,
    parameter int NPUSH = 3,
    localparam int OW   = $clog2(DEPTH)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPUSH-1:0]           push_en,
    input  logic [NPUSH-1:0]           push_bit,
    input  logic [NPUSH-1:0][OW-1:0]   push_ofs,
    input  logic                       swap,
    input  logic [OW-1:0]              rd_ofs,
    output logic                       rd_bit
);
    typedef struct packed {
        logic                  fsel;
        logic [1:0][DEPTH-1:0] slot;
    } lifo_t;

    lifo_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        // bits arrive newest first; placing them by column offset reverses them
        for (int m = 0; m < NPUSH; m++) begin
            if (push_en[m]) nxt_d.slot[cur_q.fsel][push_ofs[m]] = push_bit[m];
        end
        if (swap) nxt_d.fsel = ~cur_q.fsel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rd_bit = cur_q.slot[~cur_q.fsel][rd_ofs];
endmodule

// File: rtl/tbu_onepointer.sv
module tbu_onepointer #(
    parameter int K_LEN = 3,
    parameter int TRUNC = 8,
    parameter int SPEED = 3,
    localparam int SW    = K_LEN - 1,
    localparam int NS    = 1 << SW,
    localparam int DEPTH = TRUNC / (SPEED - 1),
    localparam int NBANK = SPEED + 1,
    localparam int NCOL  = NBANK * DEPTH,
    localparam int CW    = $clog2(NCOL),
    localparam int BW    = $clog2(NBANK),
    localparam int OW    = $clog2(DEPTH),
    localparam int FW    = $clog2(SPEED + 1),
    localparam int SIW   = $clog2(SPEED * DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [NS-1:0] in_dec,
    input  logic [SW-1:0] in_best,
    output logic          out_valid,
    output logic          out_bit
);
    typedef struct packed {
        logic [BW-1:0] bank;   // bank being written
        logic [OW-1:0] ofs;    // column within that bank
        logic [FW-1:0] full;   // completed banks, saturating at SPEED
        logic [SW-1:0] best;   // best state of the latest column
        logic [SW-1:0] ptr;    // read pointer state
        logic          drain;  // a decoded group is waiting to drain
        logic          ov;
        logic          ob;
    } ctl_t;

    ctl_t cur_q, nxt_d;

    logic                      rd_go, last_col, swap;
    logic [SW-1:0]             start_state, end_state;
    logic [CW-1:0]             head_col, wr_col;
    logic [SIW-1:0]            step0;
    logic [SPEED-1:0][CW-1:0]  rd_col;
    logic [SPEED-1:0][NS-1:0]  rd_dec;
    logic [SPEED-1:0]          chain_push, push_en, push_bit;
    logic [SPEED-1:0][OW-1:0]  push_ofs;
    logic                      lifo_bit;

    always_comb begin
        rd_go       = (cur_q.full == FW'(SPEED));
        last_col    = (cur_q.ofs == OW'(DEPTH - 1));
        start_state = (cur_q.ofs == '0) ? cur_q.best : cur_q.ptr;
        step0       = SIW'(32'(cur_q.ofs) * SPEED);
        head_col    = CW'(32'(cur_q.bank) * DEPTH);
        wr_col      = CW'(32'(cur_q.bank) * DEPTH + 32'(cur_q.ofs));
        swap        = in_valid && last_col && rd_go;
        push_en     = (in_valid && rd_go) ? chain_push : '0;

        nxt_d    = cur_q;
        nxt_d.ov = 1'b0;
        if (in_valid) begin
            nxt_d.best = in_best;
            nxt_d.ov   = cur_q.drain;
            nxt_d.ob   = lifo_bit;
            if (rd_go) nxt_d.ptr = end_state;
            if (last_col) begin
                nxt_d.ofs   = '0;
                nxt_d.bank  = (cur_q.bank == BW'(NBANK - 1)) ? '0 : cur_q.bank + BW'(1);
                nxt_d.drain = rd_go;
                if (!rd_go) nxt_d.full = cur_q.full + FW'(1);
            end else begin
                nxt_d.ofs = cur_q.ofs + OW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_valid = cur_q.ov;
    assign out_bit   = cur_q.ob;

    tbu_surv_mem #(.NS(NS), .NCOL(NCOL), .NRD(SPEED)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (in_valid),
        .wr_col (wr_col),
        .wr_dec (in_dec),
        .rd_col (rd_col),
        .rd_dec (rd_dec)
    );

    tbu_trace_chain #(.SW(SW), .DEPTH(DEPTH), .SPEED(SPEED)) u_chain (
        .start_state (start_state),
        .head_col    (head_col),
        .step0       (step0),
        .rd_dec      (rd_dec),
        .rd_col      (rd_col),
        .end_state   (end_state),
        .push_en     (chain_push),
        .push_bit    (push_bit),
        .push_ofs    (push_ofs)
    );

    tbu_rev_lifo #(.DEPTH(DEPTH), .NPUSH(SPEED)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (push_en),
        .push_bit (push_bit),
        .push_ofs (push_ofs),
        .swap     (swap),
        .rd_ofs   (cur_q.ofs),
        .rd_bit   (lifo_bit)
    );
endmodule

// File: rtl/tbu_chk.sv
module tbu_chk #(
    parameter int TRUNC = 8,
    parameter int SPEED = 3
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic out_valid,
    input logic out_bit
);
    localparam int LAT  = (SPEED + 1) * TRUNC / (SPEED - 1);
    localparam int CNTW = $clog2(LAT + 2);

    logic [CNTW-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  seen_q <= '0;
        else if (in_valid && seen_q <= CNTW'(LAT))   seen_q <= seen_q + CNTW'(1);
    end

    AST_QUIET_UNTIL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen_q > CNTW'(LAT)));                                        // R1
    AST_ONE_PER_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && seen_q >= CNTW'(LAT)) |=> out_valid);                           // R2
    AST_OUT_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$isunknown(out_bit));                                         // R3
    AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);                                                   // R4
endmodule

bind tbu_onepointer tbu_chk #(.TRUNC(TRUNC), .SPEED(SPEED)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_bit   (out_bit)
);

// File: tb/sim_tbu_onepointer.sv
module sim_tbu_onepointer;
    localparam int K_LEN      = 3;
    localparam int TRUNC      = 8;
    localparam int SPEED      = 3;
    localparam int SW         = K_LEN - 1;
    localparam int NS         = 1 << SW;
    localparam int LAT        = (SPEED + 1) * TRUNC / (SPEED - 1);
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [NS-1:0] in_dec = '0;
    logic [SW-1:0] in_best = '0;
    logic          out_valid, out_bit;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;
    bit pend_v = 1'b0;
    bit pend_b = 1'b0;
    bit ref_q[$];
    logic [SW-1:0] tstate = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tbu_onepointer #(.K_LEN(K_LEN), .TRUNC(TRUNC), .SPEED(SPEED)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_dec    (in_dec),
        .in_best   (in_best),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    // one clock: compare the previous edge's result, then drive the next stimulus
    task automatic cycle(input bit v, input bit hold_rst, input string tag);
        bit u;
        logic [SW-1:0] prev;
        @(negedge clk);
        total++;
        if (out_valid !== pend_v) begin
            bad++;
            $display("FAIL %s out_valid=%0b expected %0b", tag, out_valid, pend_v);
        end
        if (pend_v) begin
            total++;
            if (out_bit !== pend_b) begin
                bad++;
                $display("FAIL %s out_bit=%0b expected %0b", tag, out_bit, pend_b);
            end
        end
        rst_n = !hold_rst;
        if (hold_rst) begin
            in_valid = 1'b0;
            ref_q.delete();
            tstate = '0;
            pend_v = 1'b0;
        end else if (v) begin
            u      = 1'($urandom % 2);
            prev   = tstate;
            tstate = (prev >> 1) | (SW'(u) << (SW - 1));
            // off-path decisions random (R5); on-path bit gives the true predecessor (R6)
            in_dec         = NS'($urandom);
            in_dec[tstate] = prev[0];
            in_best        = tstate;
            in_valid       = 1'b1;
            ref_q.push_back(u);
            if (ref_q.size() > LAT) begin
                pend_v = 1'b1;
                pend_b = ref_q.pop_front();
            end else begin
                pend_v = 1'b0;
            end
        end else begin
            // idle: garbage on data pins must be ignored (R4)
            in_valid = 1'b0;
            in_dec   = NS'($urandom);
            in_best  = SW'($urandom);
            pend_v   = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        // R1: held in reset, then the first LAT stages give no output
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b1, "R1");
        for (int i = 0; i < LAT; i++) cycle(1'b1, 1'b0, "R1");
        // R2 R3 R6: back-to-back stages, decoded bits in order at latency LAT
        for (int i = 0; i < 240; i++) cycle(1'b1, 1'b0, "R2_R3");
        // R4 R5: random idle gaps with garbage inputs, random off-path decisions
        for (int i = 0; i < 600; i++) cycle(($urandom % 3) != 0, 1'b0, "R4_R5");
        // R7: reset mid-stream, latency restarts from zero
        for (int i = 0; i < 2; i++) cycle(1'b0, 1'b1, "R7");
        for (int i = 0; i < 300; i++) cycle(($urandom % 4) != 0, 1'b0, "R7");
        // R5 again with sparse traffic, one stage in three cycles
        for (int i = 0; i < 300; i++) cycle((i % 3) == 0, 1'b0, "R5");
        cycle(1'b0, 1'b0, "R4");
        finish_run();
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            finish_run();
        end
    end
endmodule